// File: doc/BRIEF.md
# Multi-mode host control port

This block sits between a device's host pins and its internal memory and register bus. At reset it latches whether the device is a slave on a two-wire serial link or loads itself without a host. It watches the latch pin and moves to a four-wire serial link when that pin falls three times. A bit-level two-wire engine outside the block presents the two-wire traffic as byte events with a start marker. The four-wire traffic (latch, clock and data in/out) is sampled directly on the system clock.

Each frame carries a device-address byte with a read/write flag, then a two-byte subaddress, then data. The block converts the data into bus words whose width depends on the region addressed. It issues one write strobe per complete word and steps the subaddress for bursts. For reads it fetches words from the bus and returns them byte by byte, most significant byte first.

Top module: `ctl_port_front`

## Requirements
- R1: At reset the strap `boot_strap` is latched. Low gives the two-wire slave mode (`mode_o`=0) and high gives the self-load mode (`mode_o`=2). `mode_o`=1 is the four-wire mode.
- R2: In the two-wire mode, the third falling edge of `latch_n` since reset switches `mode_o` to 1 on the following clock. One or two falling edges leave the mode unchanged.
- R3: The four-wire mode holds until reset. Reset clears the falling-edge count, so edges seen before a reset do not add to the count after it.
- R4: In the self-load mode all host traffic, on either link, is ignored. No bus strobe is issued and the mode never changes.
- R5: Byte 0 of a frame holds the device address in bits 7:1 and the read flag in bit 0 (1 = read). Bytes 1 and 2 give the subaddress, high byte first. Later bytes are data.
- R6: The device address is the top five bits of `DEV_BASE` followed by `addr_sel`. If byte 0 does not match it, the frame is ignored until the next start (two-wire start event or `latch_n` fall in four-wire mode).
- R7: A word is 4 bytes for subaddresses below 1024, 5 bytes from 1024 to 2047, and 2 bytes from 2048 up. `bus_we` pulses one cycle after the last byte of a word. `bus_wdata` is right-aligned with the first byte most significant, and upper bytes are zero.
- R8: In a burst the subaddress rises by one after each complete word, and the word size is taken afresh for each new subaddress.
- R9: On a read frame `bus_rd` pulses with `bus_addr` after the subaddress arrives, and `rd_data` is taken in that cycle. Its low word-size bytes appear on `rd_byte`, most significant first, and each byte slot advances to the next byte. After a full word the next subaddress is read. `bus_rd` and `bus_we` are never high together.
- R10: In four-wire mode `mosi` is sampled MSB first on rising `sclk` while `latch_n` is low. `cout` shifts out read bytes MSB first. `latch_n` high ends the frame and drops any partial byte or word.
- R11: A new start discards a partially received word, and no strobe is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are latched while low |
| boot_strap | input | 1 | Self-load strap |
| addr_sel | input | 2 | Low bits of the device address |
| latch_n | input | 1 | Four-wire latch / mode-entry pin |
| sclk | input | 1 | Four-wire serial clock |
| mosi | input | 1 | Four-wire serial data in |
| cout | output | 1 | Four-wire serial data out |
| i2c_start | input | 1 | Two-wire start event from the bit engine |
| i2c_byte_vld | input | 1 | Two-wire byte received or byte slot consumed |
| i2c_byte | input | 8 | Two-wire received byte |
| mode_o | output | 2 | Active mode: 0 two-wire, 1 four-wire, 2 self-load |
| bus_we | output | 1 | Word write strobe |
| bus_rd | output | 1 | Word read strobe |
| bus_addr | output | 16 | Word address for the strobe |
| bus_wdata | output | 40 | Right-aligned write word |
| rd_data | input | 40 | Read word, valid while `bus_rd` is high |
| rd_byte | output | 8 | Current read byte returned to the host |

## Verification
A wrong falling-edge count or a lost mode bit shows on `mode_o` in the clock after the third `latch_n` fall, or after a reset. The bench compares that port on every cycle. A wrong frame phase or byte counter shows on the next word boundary: a write strobe that is missing, extra, late, carries the wrong address, or is packed with the wrong byte count. A burst that crosses a region edge exposes a stale word-size choice within one word. Read-path faults appear on `rd_byte` or `cout` at the first byte after the subaddress.

// File: rtl/ctl_port_front.sv
module ctl_port_front #(
  parameter logic [6:0] DEV_BASE    = 7'h34,
  parameter int         PARAM_WORDS = 1024,
  parameter int         PROG_WORDS  = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_strap,
  input  logic [1:0]  addr_sel,
  input  logic        latch_n,
  input  logic        sclk,
  input  logic        mosi,
  output logic        cout,
  input  logic        i2c_start,
  input  logic        i2c_byte_vld,
  input  logic [7:0]  i2c_byte,
  output logic [1:0]  mode_o,
  output logic        bus_we,
  output logic        bus_rd,
  output logic [15:0] bus_addr,
  output logic [39:0] bus_wdata,
  input  logic [39:0] rd_data,
  output logic [7:0]  rd_byte
);

  localparam int MAXB   = 5;
  localparam int WORD_W = 8 * MAXB;

  typedef enum logic [1:0] {M_I2C = 2'd0, M_SPI = 2'd1, M_BOOT = 2'd2} mode_t;
  typedef enum logic [2:0] {F_IDLE, F_CHIP, F_SUBH, F_SUBL, F_DATA, F_READ} phase_t;

  function automatic logic [2:0] word_bytes(input logic [15:0] a);
    if (int'(a) < PARAM_WORDS) return 3'd4;
    else if (int'(a) < PARAM_WORDS + PROG_WORDS) return 3'd5;
    else return 3'd2;
  endfunction

  mode_t              mode_q;
  logic [1:0]         pulse_cnt;
  logic               latch_q, sclk_q;
  logic [2:0]         bit_cnt;
  logic [6:0]         spi_sh;
  phase_t             ph;
  logic               rw_q;
  logic [15:0]        addr_q;
  logic [2:0]         byte_cnt;
  logic [WORD_W-1:0]  acc, txbuf;

  wire        in_i2c     = (mode_q == M_I2C);
  wire        in_spi     = (mode_q == M_SPI);
  wire        latch_fall = latch_q & ~latch_n;
  wire        sclk_rise  = sclk & ~sclk_q;
  wire        spi_done   = in_spi & ~latch_n & sclk_rise & (bit_cnt == 3'd7);
  wire        spi_abort  = in_spi & latch_n;
  wire        start_ev   = (in_i2c & i2c_start) | (in_spi & latch_fall);
  wire        byte_ev    = (in_i2c & i2c_byte_vld) | spi_done;
  wire [7:0]  rx_byte    = in_spi ? {spi_sh, mosi} : i2c_byte;
  wire [6:0]  dev_id     = {DEV_BASE[6:2], addr_sel};
  wire [2:0]  nb_cur     = word_bytes(addr_q);
  wire        word_end   = (byte_cnt == nb_cur - 3'd1);
  wire [WORD_W-1:0] acc_nx = {acc[WORD_W-9:0], rx_byte};

  assign mode_o  = mode_q;
  assign rd_byte = txbuf[WORD_W-1 -: 8];
  assign cout    = (in_spi && !latch_n && ph == F_READ) ? rd_byte[3'd7 - bit_cnt] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= boot_strap ? M_BOOT : M_I2C;
      pulse_cnt <= '0;
      latch_q   <= 1'b1;
      sclk_q    <= 1'b0;
    end else begin
      latch_q <= latch_n;
      sclk_q  <= sclk;
      if (in_i2c && latch_fall) begin
        if (pulse_cnt == 2'd2) begin
          mode_q    <= M_SPI;
          pulse_cnt <= '0;
        end else begin
          pulse_cnt <= pulse_cnt + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      spi_sh  <= '0;
    end else if (!in_spi || latch_n) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      spi_sh  <= {spi_sh[5:0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= F_IDLE;
      rw_q      <= 1'b0;
      addr_q    <= '0;
      byte_cnt  <= '0;
      acc       <= '0;
      txbuf     <= '0;
      bus_we    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_we <= 1'b0;
      bus_rd <= 1'b0;
      if (spi_abort) begin
        ph <= F_IDLE;
      end else if (start_ev) begin
        ph       <= F_CHIP;
        byte_cnt <= '0;
        acc      <= '0;
      end else if (byte_ev) begin
        case (ph)
          F_CHIP: begin
            if (rx_byte[7:1] == dev_id) begin
              rw_q <= rx_byte[0];
              ph   <= F_SUBH;
            end else begin
              ph <= F_IDLE;
            end
          end
          F_SUBH: begin
            addr_q[15:8] <= rx_byte;
            ph           <= F_SUBL;
          end
          F_SUBL: begin
            addr_q[7:0] <= rx_byte;
            if (rw_q) begin
              ph       <= F_READ;
              bus_rd   <= 1'b1;
              bus_addr <= {addr_q[15:8], rx_byte};
            end else begin
              ph <= F_DATA;
            end
          end
          F_DATA: begin
            if (word_end) begin
              bus_we    <= 1'b1;
              bus_addr  <= addr_q;
              bus_wdata <= acc_nx;
              addr_q    <= addr_q + 16'd1;
              acc       <= '0;
              byte_cnt  <= '0;
            end else begin
              acc      <= acc_nx;
              byte_cnt <= byte_cnt + 3'd1;
            end
          end
          F_READ: begin
            txbuf <= {txbuf[WORD_W-9:0], 8'h00};
            if (word_end) begin
              addr_q   <= addr_q + 16'd1;
              bus_rd   <= 1'b1;
              bus_addr <= addr_q + 16'd1;
              byte_cnt <= '0;
            end else begin
              byte_cnt <= byte_cnt + 3'd1;
            end
          end
          default: ;
        endcase
      end
      if (bus_rd)
        txbuf <= rd_data << (8 * (MAXB - int'(word_bytes(bus_addr))));
    end
  end

  // R1
  boot_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) != M_BOOT) |-> (mode_q != M_BOOT));

  // R2
  spi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SPI && $past(mode_q) == M_I2C) |-> $past(latch_fall));

  // R3
  spi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SPI) |=> (mode_q == M_SPI));

  // R4
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_BOOT) |-> (!bus_we && !bus_rd));

  // R7
  word_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> ((bus_wdata >> (8 * int'(word_bytes(bus_addr)))) == '0));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_rd));

endmodule

// File: tb/ctl_port_front_bench.sv
`timescale 1ns/1ps
module ctl_port_front_bench;
  localparam logic [6:0] DEV = 7'h35;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, boot_strap = 1'b0;
  logic [1:0]  addr_sel = 2'b01;
  logic        latch_n = 1'b1, sclk = 1'b0, mosi = 1'b0, cout;
  logic        i2c_start = 1'b0, i2c_byte_vld = 1'b0;
  logic [7:0]  i2c_byte = 8'h00, rd_byte;
  logic [1:0]  mode_o;
  logic        bus_we, bus_rd;
  logic [15:0] bus_addr;
  logic [39:0] bus_wdata, rd_data;

  function automatic logic [39:0] mem_word(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h21, ~a[7:0], a[7:0] + 8'h33, a[15:8] ^ a[7:0]};
  endfunction
  assign rd_data = mem_word(bus_addr);

  ctl_port_front u_ctl_port_front (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .addr_sel(addr_sel),
    .latch_n(latch_n), .sclk(sclk), .mosi(mosi), .cout(cout),
    .i2c_start(i2c_start), .i2c_byte_vld(i2c_byte_vld), .i2c_byte(i2c_byte),
    .mode_o(mode_o), .bus_we(bus_we), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_byte(rd_byte));

  int vecs = 0, errs = 0, exp_mode = 0, m_pulses = 0;
  bit done = 1'b0;
  logic [55:0] expq[$];
  logic [7:0]  pl[$];
  logic [7:0]  last_rx;

  function automatic int nbm(input logic [15:0] a);
    if (a < 16'd1024) return 4;
    else if (a < 16'd2048) return 5;
    else return 2;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R1 R2 R3 mode", 64'(mode_o), 64'(exp_mode));
      if (bus_we) begin
        if (expq.size() == 0) chk("R7 R8 unexpected write", 64'(bus_addr), 64'hFFFF_FFFF);
        else chk("R7 R8 write word", {bus_addr, bus_wdata}, 64'(expq.pop_front()));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; boot_strap = strap;
    exp_mode = strap ? 2 : 0; m_pulses = 0; expq.delete();
    tick(4);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic latch_low();
    @(negedge clk);
    latch_n = 1'b0;
    if (exp_mode == 0) begin
      m_pulses++;
      if (m_pulses == 3) begin exp_mode = 1; m_pulses = 0; end
    end
    tick(1);
  endtask

  task automatic latch_high();
    @(negedge clk);
    latch_n = 1'b1;
    tick(2);
  endtask

  task automatic latch_pulse();
    latch_low(); latch_high();
  endtask

  task automatic i2c_st();
    @(negedge clk) i2c_start = 1'b1;
    @(negedge clk) i2c_start = 1'b0;
    tick(1);
  endtask

  task automatic i2c_tx(input logic [7:0] b);
    @(negedge clk) begin i2c_byte = b; i2c_byte_vld = 1'b1; end
    @(negedge clk) i2c_byte_vld = 1'b0;
    tick(2);
  endtask

  task automatic spi_tx(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk) begin sclk = 1'b0; mosi = b[i]; end
      @(negedge clk) last_rx[i] = cout;
      @(negedge clk) sclk = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic put_byte(input bit spi, input logic [7:0] b);
    if (spi) spi_tx(b, 8); else i2c_tx(b);
  endtask

  task automatic send_frame(input bit spi, input logic [6:0] chip, input bit rw, input logic [15:0] a);
    logic [15:0] cur; logic [39:0] acc; int k;
    if (chip == DEV && exp_mode == (spi ? 1 : 0) && !rw) begin
      cur = a; acc = '0; k = 0;
      foreach (pl[i]) begin
        acc = {acc[31:0], pl[i]}; k++;
        if (k == nbm(cur)) begin
          expq.push_back({cur, acc}); cur++; acc = '0; k = 0;
        end
      end
    end
    if (spi) latch_low(); else i2c_st();
    put_byte(spi, {chip, rw});
    put_byte(spi, a[15:8]);
    put_byte(spi, a[7:0]);
    if (!rw) foreach (pl[i]) put_byte(spi, pl[i]);
  endtask

  task automatic drain(input string req);
    tick(4);
    chk(req, 64'(expq.size()), 64'd0);
  endtask

  task automatic read_words(input bit spi, input logic [15:0] a, input int nw);
    logic [15:0] cur; logic [39:0] w; int n;
    send_frame(spi, DEV, 1'b1, a);
    cur = a;
    for (int j = 0; j < nw; j++) begin
      n = nbm(cur); w = mem_word(cur);
      for (int k = 0; k < n; k++) begin
        if (spi) begin
          spi_tx(8'h00, 8);
          chk("R9 R10 serial read byte", 64'(last_rx), 64'(w[8*(n-1-k) +: 8]));
        end else begin
          chk("R9 read byte", 64'(rd_byte), 64'(w[8*(n-1-k) +: 8]));
          i2c_tx(8'h00);
        end
      end
      cur++;
    end
    if (spi) latch_high();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1; errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    chk("R1 reset mode two-wire", 64'(mode_o), 64'd0);
    chk("R1 reset no strobe", 64'({bus_we, bus_rd}), 64'd0);

    // R5 R7 single parameter word
    pl = '{8'h11, 8'h22, 8'h33, 8'h44};
    send_frame(1'b0, DEV, 1'b0, 16'h0010); drain("R5 R7 single word");

    // R8 burst crossing from parameter to program region
    pl = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5};
    send_frame(1'b0, DEV, 1'b0, 16'h03FF); drain("R8 burst region cross");

    // R7 register words of two bytes
    pl = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    send_frame(1'b0, DEV, 1'b0, 16'h0800); drain("R7 register burst");

    // R6 mismatched device address, trailing bytes ignored
    pl = '{8'h01, 8'h02, 8'h03, 8'h04};
    send_frame(1'b0, 7'h34, 1'b0, 16'h0010);
    i2c_tx(8'h55); i2c_tx(8'h66); i2c_tx(8'h77); i2c_tx(8'h88);
    drain("R6 mismatch ignored");
    send_frame(1'b0, DEV, 1'b0, 16'h0020); drain("R6 next start accepted");

    // R11 partial word dropped by new start
    i2c_st(); i2c_tx({DEV, 1'b0}); i2c_tx(8'h00); i2c_tx(8'h10); i2c_tx(8'h99); i2c_tx(8'h98);
    pl = '{8'h41, 8'h42, 8'h43, 8'h44};
    send_frame(1'b0, DEV, 1'b0, 16'h0012); drain("R11 partial word discarded");

    // R9 two-wire reads, register then program region
    read_words(1'b0, 16'h0810, 2);
    read_words(1'b0, 16'h0400, 1);
    drain("R9 no writes during read");

    // R2 two pulses keep mode, third enters four-wire
    latch_pulse(); latch_pulse();
    chk("R2 two pulses", 64'(mode_o), 64'd0);
    latch_pulse();
    chk("R2 third pulse", 64'(mode_o), 64'd1);

    // R3 two-wire traffic ignored once in four-wire mode
    pl = '{8'h01, 8'h02, 8'h03, 8'h04};
    send_frame(1'b0, DEV, 1'b0, 16'h0010); drain("R3 two-wire ignored");

    // R10 four-wire writes
    pl = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
    send_frame(1'b1, DEV, 1'b0, 16'h0020); latch_high(); drain("R10 serial write");
    pl = '{8'h12, 8'h34, 8'h56, 8'h78};
    send_frame(1'b1, DEV, 1'b0, 16'h0801); latch_high(); drain("R10 R8 serial burst");

    // R10 abort mid frame and mid byte
    latch_low(); spi_tx({DEV, 1'b0}, 8); spi_tx(8'h08, 8); spi_tx(8'h05, 8);
    spi_tx(8'hEE, 8); spi_tx(8'hFF, 3); latch_high();
    drain("R10 abort drops word");
    pl = '{8'h9A, 8'hBC};
    send_frame(1'b1, DEV, 1'b0, 16'h0805); latch_high(); drain("R10 after abort");

    // R9 R10 four-wire read
    read_words(1'b1, 16'h0802, 2);
    chk("R3 still four-wire", 64'(mode_o), 64'd1);

    // R3 reset returns to two-wire, count cleared
    do_reset(1'b0);
    chk("R3 reset leaves four-wire", 64'(mode_o), 64'd0);
    latch_pulse(); latch_pulse();
    do_reset(1'b0);
    latch_pulse(); latch_pulse();
    chk("R3 count cleared by reset", 64'(mode_o), 64'd0);
    latch_pulse();
    chk("R3 entry after fresh count", 64'(mode_o), 64'd1);

    // R1 R4 self-load strap
    do_reset(1'b1);
    chk("R1 strap high", 64'(mode_o), 64'd2);
    pl = '{8'h01, 8'h02, 8'h03, 8'h04};
    send_frame(1'b0, DEV, 1'b0, 16'h0010);
    latch_pulse(); latch_pulse(); latch_pulse();
    send_frame(1'b1, DEV, 1'b0, 16'h0010); latch_high();
    drain("R4 self-load ignores host");
    chk("R4 mode held", 64'(mode_o), 64'd2);

    tick(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule